// File: doc/BRIEF.md
# SPI Transmit/Receive FIFO Occupancy and Interrupt Flag Controller

This block holds the transmit and receive queues of a serial peripheral and derives every occupancy flag and FIFO interrupt from them. The bus side writes words into the transmit queue and reads words from the receive queue. The shifter side drains the transmit queue and fills the receive queue. A word-size select chooses between 8-bit words (one byte per entry) and 16-bit words (two bytes per entry). Each queue holds 8 bytes, so it holds 8 narrow entries or 4 wide ones.

The block reports empty, full and sticky overflow for each direction. It also reports a transmit nearly-empty flag and a receive nearly-full flag, each with a selectable watermark expressed in bits. Four interrupt lines either follow their flags directly or are latched on a rising flag and released by write-one clear strobes. Two level DMA requests are gated by their enables, and an enabled DMA request mutes the matching empty or full interrupt.

All four data ports are valid/ready. Output sides (`tx_out_*`, `rx_out_*`) follow normal back-pressure: a word is moved on a cycle where valid and ready are both high, and valid stays high while a word is waiting. Input sides (`tx_in_*`, `rx_in_*`) are push attempts: every cycle with valid high is one attempt. When ready is low that attempt is dropped and counted as an overflow, so a source must look at ready before it raises valid and must not hold valid high to wait. The word size may change only while both queues are empty.

Top module: `spi_fifo_wm_ctl`

## Requirements
- R1: Words leave each queue in the order they entered. An 8-bit word uses one byte of the 8-byte capacity and a 16-bit word uses two. In 8-bit mode the upper byte of an output word reads as zero.
- R2: A queue's full flag is 1 exactly when 8 bytes are held, and its empty flag is 1 exactly when 0 bytes are held. Input ready is 1 only when one more word still fits. Output valid is 1 when at least one whole word is held.
- R3: `tx_near_empty` is 1 when the transmit queue holds at most 16 bits (`tx_mark` = 0) or at most 32 bits (`tx_mark` = 1).
- R4: `rx_near_full` is 1 when the receive queue holds at least 48 bits (`rx_mark` = 0) or at least 32 bits (`rx_mark` = 1).
- R5: A push attempt while input ready is 0 leaves the queue unchanged and sets that direction's overflow flag on the next cycle. The flag then stays set.
- R6: Reset clears both overflow flags. While `fifo_mode` is 0 both overflow flags read 0 from the next cycle.
- R7: With `clr_sel` = 0, each interrupt bit equals its flag ANDed with its enable, in the same cycle.
- R8: With `clr_sel` = 1, a latch for each interrupt sets on the clock edge that first sees its flag at 1 after seeing it at 0. The latch is cleared only by its bit of `irq_clr`, and a new rise wins over a clear in the same cycle. While `clr_sel` is 0 all latches are held at 0.
- R9: Interrupt bit order is 0 receive full, 1 transmit empty, 2 receive nearly full, 3 transmit nearly empty, and `irq_clr` uses the same order. Bit 0 needs `ie_rx_full` and is forced to 0 while `rx_dma_en` is 1. Bit 1 needs `ie_tx_empty` and is forced to 0 while `tx_dma_en` is 1. Bits 2 and 3 need `ie_rx_nfull` and `ie_tx_nempty`.
- R10: `tx_dma_req` equals `tx_dma_en` AND `tx_in_ready`. `rx_dma_req` equals `rx_dma_en` AND `rx_out_valid`.
- R11: After reset both queues are empty, the nearly-empty flag is 1, and the nearly-full flag, both overflow flags, all interrupt latches and every interrupt line are 0.
- R12: When a push and a pop occur in the same cycle, input ready is based on the occupancy before the pop. A full queue therefore refuses a push even in the cycle it is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| fifo_mode | input | 1 | 0 clears and holds both overflow flags |
| tx_mark | input | 1 | Transmit nearly-empty watermark select |
| rx_mark | input | 1 | Receive nearly-full watermark select |
| clr_sel | input | 1 | 0 = interrupts follow flags, 1 = latched with explicit clear |
| irq_clr | input | 4 | Write-one clear strobes, order as R9 |
| ie_rx_full | input | 1 | General enable for the receive-full interrupt |
| ie_tx_empty | input | 1 | Transmit-empty interrupt enable |
| ie_rx_nfull | input | 1 | Receive nearly-full interrupt enable |
| ie_tx_nempty | input | 1 | Transmit nearly-empty interrupt enable |
| tx_dma_en | input | 1 | Transmit DMA enable |
| rx_dma_en | input | 1 | Receive DMA enable |
| tx_in_valid | input | 1 | Bus push attempt into the transmit queue |
| tx_in_ready | output | 1 | Transmit queue can take a word |
| tx_in_data | input | 16 | Word pushed by the bus |
| tx_out_valid | output | 1 | Transmit word available to the shifter |
| tx_out_ready | input | 1 | Shifter takes the transmit word |
| tx_out_data | output | 16 | Oldest transmit word |
| rx_in_valid | input | 1 | Shifter push attempt into the receive queue |
| rx_in_ready | output | 1 | Receive queue can take a word |
| rx_in_data | input | 16 | Word pushed by the shifter |
| rx_out_valid | output | 1 | Received word available to the bus |
| rx_out_ready | input | 1 | Bus reads the received word |
| rx_out_data | output | 16 | Oldest received word |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue holds 8 bytes |
| tx_near_empty | output | 1 | Transmit watermark reached |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue holds 8 bytes |
| rx_near_full | output | 1 | Receive watermark reached |
| rx_ovf | output | 1 | Sticky receive overflow |
| irq | output | 4 | Interrupt lines, order as R9 |
| tx_dma_req | output | 1 | Transmit DMA request level |
| rx_dma_req | output | 1 | Receive DMA request level |

## Verification
The assertions check these properties on every cycle:
- a full queue refuses pushes and an empty queue offers no word;
- each empty or full flag implies its watermark flag;
- a dropped push raises overflow, and overflow stays set until mode-off clears it;
- an enabled DMA request keeps its interrupt line low.

Other behaviour needs the bench's traffic and its reference queues:
- word ordering and the byte-lane masking;
- the exact watermark thresholds in both word sizes;
- the rise-then-clear timing of the latched interrupts;
- the case where a push and a pop meet at full.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;

  localparam int unsigned FLAG_N = 4;

  typedef enum int unsigned {
    FL_RX_FULL   = 0,
    FL_TX_EMPTY  = 1,
    FL_RX_NFULL  = 2,
    FL_TX_NEMPTY = 3
  } flag_idx_e;

  typedef logic [FLAG_N-1:0] flag_vec_t;

  // Flag values that hold right after reset (both queues empty).
  localparam flag_vec_t FLAGS_AT_RESET =
    flag_vec_t'((1 << FL_TX_EMPTY) | (1 << FL_TX_NEMPTY));

endpackage

// File: rtl/spi_wm_fifo.sv
// Byte-accounted queue: each entry carries one or two bytes depending on wide.
module spi_wm_fifo #(
  parameter int unsigned BYTES = 8,
  parameter int unsigned DW    = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wide,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [DW-1:0]                in_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [DW-1:0]                out_data,
  output logic [$clog2(BYTES+1)-1:0]   level,
  output logic                         drop
);

  localparam int unsigned ENTRIES = BYTES;
  localparam int unsigned AW      = $clog2(ENTRIES);
  localparam int unsigned CW      = $clog2(BYTES+1);
  localparam int unsigned HALF    = DW / 2;

  logic [DW-1:0] mem [ENTRIES];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] step;
  logic          push, pop;

  assign step      = wide ? CW'(2) : CW'(1);
  assign in_ready  = ({1'b0, level} + {1'b0, step}) <= (CW+1)'(BYTES);
  assign out_valid = level >= step;
  assign push      = in_valid & in_ready;
  assign pop       = out_valid & out_ready;
  assign drop      = in_valid & ~in_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= wptr + AW'(1);
      if (pop)  rptr <= rptr + AW'(1);
      level <= level + (push ? step : CW'(0)) - (pop ? step : CW'(0));
    end
  end

  assign out_data = wide ? mem[rptr] : {{(DW-HALF){1'b0}}, mem[rptr][HALF-1:0]};

endmodule

// File: rtl/spi_wm_mark.sv
// Watermark comparator; thresholds given in bits, selected by sel.
module spi_wm_mark #(
  parameter int unsigned BYTES     = 8,
  parameter int unsigned MARK0_BITS = 16,
  parameter int unsigned MARK1_BITS = 32,
  parameter bit          AT_MOST   = 1'b1
) (
  input  logic [$clog2(BYTES+1)-1:0] level,
  input  logic                       sel,
  output logic                       flag
);

  localparam int unsigned CW = $clog2(BYTES+1);
  localparam logic [CW-1:0] M0 = CW'(MARK0_BITS / 8);
  localparam logic [CW-1:0] M1 = CW'(MARK1_BITS / 8);

  logic [CW-1:0] mark;
  assign mark = sel ? M1 : M0;

  generate
    if (AT_MOST) begin : g_le
      assign flag = level <= mark;
    end else begin : g_ge
      assign flag = level >= mark;
    end
  endgenerate

endmodule

// File: rtl/spi_wm_irq.sv
// Per-flag interrupt: direct follow, or rise-latched with write-one clear.
module spi_wm_irq #(
  parameter int unsigned   N              = 4,
  parameter logic [N-1:0]  FLAGS_AT_RESET = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] gate,
  input  logic         latch_mode,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irq
);

  logic [N-1:0] flags_q;
  logic [N-1:0] pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= FLAGS_AT_RESET;
      pend    <= '0;
    end else begin
      flags_q <= flags;
      pend    <= latch_mode ? ((pend & ~clr) | (flags & ~flags_q)) : '0;
    end
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_line
      assign irq[i] = gate[i] & (latch_mode ? pend[i] : flags[i]);
    end
  endgenerate

endmodule

// File: rtl/spi_fifo_wm_ctl.sv
module spi_fifo_wm_ctl
  import spi_wm_pkg::*;
#(
  parameter int unsigned BYTES        = 8,
  parameter int unsigned DW           = 16,
  parameter int unsigned TX_LOW_BITS  = 16,
  parameter int unsigned TX_HIGH_BITS = 32,
  parameter int unsigned RX_LOW_BITS  = 48,
  parameter int unsigned RX_HIGH_BITS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide,
  input  logic          fifo_mode,
  input  logic          tx_mark,
  input  logic          rx_mark,
  input  logic          clr_sel,
  input  logic [3:0]    irq_clr,
  input  logic          ie_rx_full,
  input  logic          ie_tx_empty,
  input  logic          ie_rx_nfull,
  input  logic          ie_tx_nempty,
  input  logic          tx_dma_en,
  input  logic          rx_dma_en,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [DW-1:0] tx_in_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [DW-1:0] tx_out_data,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [DW-1:0] rx_in_data,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [DW-1:0] rx_out_data,
  output logic          tx_empty,
  output logic          tx_full,
  output logic          tx_near_empty,
  output logic          tx_ovf,
  output logic          rx_empty,
  output logic          rx_full,
  output logic          rx_near_full,
  output logic          rx_ovf,
  output logic [3:0]    irq,
  output logic          tx_dma_req,
  output logic          rx_dma_req
);

  localparam int unsigned CW = $clog2(BYTES+1);

  logic [CW-1:0] tx_level, rx_level;
  logic          tx_drop, rx_drop;
  flag_vec_t     flags, gate;

  spi_wm_fifo #(.BYTES(BYTES), .DW(DW)) u_txq (
    .clk(clk), .rst_n(rst_n), .wide(wide),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .level(tx_level), .drop(tx_drop)
  );

  spi_wm_fifo #(.BYTES(BYTES), .DW(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .wide(wide),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .level(rx_level), .drop(rx_drop)
  );

  spi_wm_mark #(.BYTES(BYTES), .MARK0_BITS(TX_LOW_BITS), .MARK1_BITS(TX_HIGH_BITS),
                .AT_MOST(1'b1)) u_tx_mark (
    .level(tx_level), .sel(tx_mark), .flag(tx_near_empty)
  );

  spi_wm_mark #(.BYTES(BYTES), .MARK0_BITS(RX_LOW_BITS), .MARK1_BITS(RX_HIGH_BITS),
                .AT_MOST(1'b0)) u_rx_mark (
    .level(rx_level), .sel(rx_mark), .flag(rx_near_full)
  );

  assign tx_empty = tx_level == '0;
  assign tx_full  = tx_level == CW'(BYTES);
  assign rx_empty = rx_level == '0;
  assign rx_full  = rx_level == CW'(BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n || !fifo_mode) begin
      tx_ovf <= 1'b0;
      rx_ovf <= 1'b0;
    end else begin
      if (tx_drop) tx_ovf <= 1'b1;
      if (rx_drop) rx_ovf <= 1'b1;
    end
  end

  always_comb begin
    flags               = '0;
    flags[FL_RX_FULL]   = rx_full;
    flags[FL_TX_EMPTY]  = tx_empty;
    flags[FL_RX_NFULL]  = rx_near_full;
    flags[FL_TX_NEMPTY] = tx_near_empty;
    gate                = '0;
    gate[FL_RX_FULL]    = ie_rx_full & ~rx_dma_en;
    gate[FL_TX_EMPTY]   = ie_tx_empty & ~tx_dma_en;
    gate[FL_RX_NFULL]   = ie_rx_nfull;
    gate[FL_TX_NEMPTY]  = ie_tx_nempty;
  end

  spi_wm_irq #(.N(FLAG_N), .FLAGS_AT_RESET(FLAGS_AT_RESET)) u_irq (
    .clk(clk), .rst_n(rst_n), .flags(flags), .gate(gate),
    .latch_mode(clr_sel), .clr(irq_clr), .irq(irq)
  );

  assign tx_dma_req = tx_dma_en & tx_in_ready;
  assign rx_dma_req = rx_dma_en & rx_out_valid;

endmodule

// File: rtl/spi_fifo_wm_ctl_chk.sv
module spi_fifo_wm_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_mode,
  input logic       tx_in_valid,
  input logic       tx_in_ready,
  input logic       rx_in_valid,
  input logic       rx_in_ready,
  input logic       tx_full,
  input logic       tx_empty,
  input logic       tx_near_empty,
  input logic       rx_full,
  input logic       rx_empty,
  input logic       rx_near_full,
  input logic       rx_out_valid,
  input logic       tx_ovf,
  input logic       rx_ovf,
  input logic       tx_dma_en,
  input logic       rx_dma_en,
  input logic [3:0] irq
);

  AST_TX_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_in_ready); // R2
  AST_RX_EMPTY_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> !rx_out_valid); // R2
  AST_TX_EMPTY_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> tx_near_empty); // R3
  AST_RX_FULL_IS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> rx_near_full); // R4
  AST_TX_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && tx_in_valid && !tx_in_ready) |=> tx_ovf); // R5
  AST_RX_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && rx_in_valid && !rx_in_ready) |=> rx_ovf); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && tx_ovf) |=> tx_ovf); // R5
  AST_MODE_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |=> (!tx_ovf && !rx_ovf)); // R6
  AST_RX_DMA_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_en |-> !irq[0]); // R9
  AST_TX_DMA_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_en |-> !irq[1]); // R9

endmodule

bind spi_fifo_wm_ctl spi_fifo_wm_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
  .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
  .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
  .tx_full(tx_full), .tx_empty(tx_empty), .tx_near_empty(tx_near_empty),
  .rx_full(rx_full), .rx_empty(rx_empty), .rx_near_full(rx_near_full),
  .rx_out_valid(rx_out_valid), .tx_ovf(tx_ovf), .rx_ovf(rx_ovf),
  .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en), .irq(irq)
);

// File: tb/spi_fifo_wm_ctl_tb.sv
`timescale 1ns/1ps
module spi_fifo_wm_ctl_tb;

  localparam int BYTES = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        wide = 1'b0, fifo_mode = 1'b1, tx_mark = 1'b0, rx_mark = 1'b0, clr_sel = 1'b0;
  logic [3:0]  irq_clr = 4'h0;
  logic        ie_rx_full = 1'b0, ie_tx_empty = 1'b0, ie_rx_nfull = 1'b0, ie_tx_nempty = 1'b0;
  logic        tx_dma_en = 1'b0, rx_dma_en = 1'b0;
  logic        tx_in_valid = 1'b0, tx_out_ready = 1'b0, rx_in_valid = 1'b0, rx_out_ready = 1'b0;
  logic [15:0] tx_in_data = '0, rx_in_data = '0;
  logic        tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [15:0] tx_out_data, rx_out_data;
  logic        tx_empty, tx_full, tx_near_empty, tx_ovf;
  logic        rx_empty, rx_full, rx_near_full, rx_ovf;
  logic [3:0]  irq;
  logic        tx_dma_req, rx_dma_req;

  spi_fifo_wm_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .wide(wide), .fifo_mode(fifo_mode),
    .tx_mark(tx_mark), .rx_mark(rx_mark), .clr_sel(clr_sel), .irq_clr(irq_clr),
    .ie_rx_full(ie_rx_full), .ie_tx_empty(ie_tx_empty), .ie_rx_nfull(ie_rx_nfull),
    .ie_tx_nempty(ie_tx_nempty), .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .tx_empty(tx_empty), .tx_full(tx_full), .tx_near_empty(tx_near_empty), .tx_ovf(tx_ovf),
    .rx_empty(rx_empty), .rx_full(rx_full), .rx_near_full(rx_near_full), .rx_ovf(rx_ovf),
    .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  int n_chk = 0, n_bad = 0;
  bit running = 1'b0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int        txq[$], rxq[$];
  bit        m_tx_ovf, m_rx_ovf;
  bit [3:0]  m_fq, m_pend;

  function automatic int stepw();
    return wide ? 2 : 1;
  endfunction

  function automatic int tx_bytes();
    return txq.size() * stepw();
  endfunction

  function automatic int rx_bytes();
    return rxq.size() * stepw();
  endfunction

  // order: 0 rx full, 1 tx empty, 2 rx nearly full, 3 tx nearly empty
  function automatic bit [3:0] mflags();
    bit ne, nf;
    ne = tx_mark ? (tx_bytes() <= 4) : (tx_bytes() <= 2);
    nf = rx_mark ? (rx_bytes() >= 4) : (rx_bytes() >= 6);
    return {ne, nf, tx_bytes() == 0, rx_bytes() == BYTES};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_tx_ovf = 0; m_rx_ovf = 0;
      m_fq = 4'b1010; m_pend = 4'b0;
    end else begin
      bit [3:0] f;
      bit txr, txv, rxr, rxv;
      int mask;
      f    = mflags();
      mask = wide ? 'hFFFF : 'hFF;
      txr  = tx_bytes() + stepw() <= BYTES;
      rxr  = rx_bytes() + stepw() <= BYTES;
      txv  = tx_bytes() >= stepw();
      rxv  = rx_bytes() >= stepw();
      m_pend = clr_sel ? ((m_pend & ~irq_clr) | (f & ~m_fq)) : 4'b0;
      m_fq   = f;
      if (!fifo_mode) begin
        m_tx_ovf = 0; m_rx_ovf = 0;
      end else begin
        if (tx_in_valid && !txr) m_tx_ovf = 1;
        if (rx_in_valid && !rxr) m_rx_ovf = 1;
      end
      if (txv && tx_out_ready) void'(txq.pop_front());
      if (rxv && rx_out_ready) void'(rxq.pop_front());
      if (tx_in_valid && txr) txq.push_back(int'(tx_in_data) & mask);
      if (rx_in_valid && rxr) rxq.push_back(int'(rx_in_data) & mask);
    end
  end

  // ---------------- compare every cycle, away from the edge ----------------
  always @(negedge clk) begin
    if (rst_n && running) begin
      bit [3:0] f, gate, src, e_irq;
      bit txr, rxr, txv, rxv;
      f   = mflags();
      txr = tx_bytes() + stepw() <= BYTES;
      rxr = rx_bytes() + stepw() <= BYTES;
      txv = tx_bytes() >= stepw();
      rxv = rx_bytes() >= stepw();
      chk("R2/R12", "tx_in_ready", tx_in_ready, txr);
      chk("R2/R12", "rx_in_ready", rx_in_ready, rxr);
      chk("R2", "tx_out_valid", tx_out_valid, txv);
      chk("R2", "rx_out_valid", rx_out_valid, rxv);
      chk("R2", "tx_empty", tx_empty, tx_bytes() == 0);
      chk("R2", "rx_empty", rx_empty, rx_bytes() == 0);
      chk("R2", "tx_full", tx_full, tx_bytes() == BYTES);
      chk("R2", "rx_full", rx_full, rx_bytes() == BYTES);
      if (txv) chk("R1", "tx_out_data", tx_out_data, txq[0]);
      if (rxv) chk("R1", "rx_out_data", rx_out_data, rxq[0]);
      chk("R3", "tx_near_empty", tx_near_empty, f[3]);
      chk("R4", "rx_near_full", rx_near_full, f[2]);
      chk(fifo_mode ? "R5" : "R6", "tx_ovf", tx_ovf, m_tx_ovf);
      chk(fifo_mode ? "R5" : "R6", "rx_ovf", rx_ovf, m_rx_ovf);
      gate  = {ie_tx_nempty, ie_rx_nfull, ie_tx_empty & ~tx_dma_en, ie_rx_full & ~rx_dma_en};
      src   = clr_sel ? m_pend : f;
      e_irq = gate & src;
      chk(clr_sel ? "R8" : "R7", "irq", irq, e_irq);
      if (rx_dma_en || tx_dma_en) chk("R9", "irq under dma", irq[1:0], e_irq[1:0]);
      chk("R10", "tx_dma_req", tx_dma_req, tx_dma_en & txr);
      chk("R10", "rx_dma_req", rx_dma_req, rx_dma_en & rxv);
    end
  end

  // ---------------- stimulus ----------------
  int p_cfg = 5, p_off = 0;

  task automatic cyc(int ptxi, int ptxo, int prxi, int prxo);
    @(posedge clk); #1;
    tx_in_valid  = ($urandom % 100) < ptxi;
    tx_out_ready = ($urandom % 100) < ptxo;
    rx_in_valid  = ($urandom % 100) < prxi;
    rx_out_ready = ($urandom % 100) < prxo;
    tx_in_data   = 16'($urandom);
    rx_in_data   = 16'($urandom);
    irq_clr      = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
    fifo_mode    = !((($urandom % 100) < p_off));
    if (($urandom % 100) < p_cfg) begin
      {tx_mark, rx_mark, clr_sel} = 3'($urandom);
      {ie_rx_full, ie_tx_empty, ie_rx_nfull, ie_tx_nempty} = 4'($urandom);
      tx_dma_en = ($urandom % 4) == 0;
      rx_dma_en = ($urandom % 4) == 0;
    end
  endtask

  task automatic phase(int n, int ptxi, int ptxo, int prxi, int prxo);
    for (int i = 0; i < n; i++) cyc(ptxi, ptxo, prxi, prxo);
  endtask

  task automatic drain();
    phase(20, 0, 100, 0, 100);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk("R11", "tx_empty", tx_empty, 1);
    chk("R11", "rx_empty", rx_empty, 1);
    chk("R11", "tx_near_empty", tx_near_empty, 1);
    chk("R11", "rx_near_full", rx_near_full, 0);
    chk("R11", "ovf", {tx_ovf, rx_ovf}, 0);
    chk("R11", "irq", irq, 0);
    chk("R11", "tx_in_ready", tx_in_ready, 1);
    running = 1'b1;
    for (int w = 0; w < 2; w++) begin
      @(posedge clk); #1 wide = w[0];
      phase(600, 90, 10, 90, 10);   // fill, overflow, full/near-full
      phase(600, 50, 50, 50, 50);   // mixed, simultaneous push/pop
      phase(600, 10, 90, 10, 90);   // near-empty region
      drain();
    end
    p_off = 20;                     // R6: mode-off clearing under traffic
    phase(400, 80, 20, 80, 20);
    p_off = 0;
    p_cfg = 30;                     // R8/R9: frequent config and clear churn
    phase(800, 60, 40, 60, 40);
    drain();
    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule